// File: doc/BRIEF.md
# Masked Vector Execute Unit

This block runs one element-wise operation over a short vector held in two source operands, under the control of a per-element mask register that lives inside the block. A start pulse captures the opcode, the source vectors, a vector length and a mode bit. Arithmetic opcodes then stream results out one element per cycle. Each result carries its element slot number and a write enable, so a register file downstream can write back only the enabled slots. Test opcodes produce no results. They rewrite the mask from an element-wise comparison, or invert it, so that a select becomes two masked moves with opposite masks.

Two ways of walking the vector are chosen per operation. In the full-sweep mode every element below the vector length comes out in ascending order, and the write enable follows its mask bit. In the skip mode the block scans the mask and spends cycles only on active elements, so the run time follows the number of set bits instead of the length. Elements are independent, so no ordering checks between them are needed.

Top module: `masked_vec_exec`

## Requirements
- R1: After reset the unit is idle (busy_o=0), produces no result (res_valid_o=0, done_o=0) and the mask register mask_o is all zeros.
- R2: Arithmetic opcodes give, modulo 2^ELEM_W on unsigned element values: 0 = a+b, 1 = a-b, 2 = low half of a*b, 3 = (a+b)>>1 with the carry kept, 7 = a. An element's result is for slot i of src_a_i[i*ELEM_W +: ELEM_W] and src_b_i.
- R3: Opcode 4 writes mask bit i = 1 when element a[i] is zero, for i below the vector length. Bits at or above it become 0. It takes one cycle, done_o is high in that cycle, and no result is emitted.
- R4: Opcode 5 writes mask bit i = 1 when a[i] >= b[i] as signed two's-complement values, for i below the length. Bits above it become 0. It takes one cycle with no result.
- R5: Opcode 6 inverts the mask bits below the vector length and clears the rest. It takes one cycle with no result.
- R6: With dense_i=0, an arithmetic op emits every slot 0..len-1 in ascending order, one per cycle, with res_we_o equal to mask bit i. It takes len cycles.
- R7: With dense_i=1, only slots whose mask bit is set and that are below the length are emitted. They come in ascending order with their original index and res_we_o=1, one per cycle, so the run takes as many cycles as there are such slots.
- R8: An arithmetic run with nothing to emit (dense with no active bit, or length 0) lasts one cycle with done_o high and no result.
- R9: A length above NUM_ELEM acts as NUM_ELEM. Mask bits at or above the length have no effect on any run.
- R10: done_o is high in the last busy cycle only, and busy_o falls after it. A start while busy is ignored.
- R11: Arithmetic opcodes leave mask_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start an operation (taken only when idle) |
| op_i | input | 3 | Opcode |
| dense_i | input | 1 | 1 = skip masked-off slots, 0 = full sweep |
| vlen_i | input | LEN_W | Vector length |
| src_a_i | input | NUM_ELEM*ELEM_W | First source vector |
| src_b_i | input | NUM_ELEM*ELEM_W | Second source vector |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last cycle of the operation |
| res_valid_o | output | 1 | A result element is presented |
| res_we_o | output | 1 | Write enable for that element |
| res_idx_o | output | IDX_W | Destination slot of the element |
| res_data_o | output | ELEM_W | Element result |
| mask_o | output | NUM_ELEM | Current mask register |

## Verification
The hardest case to reach from the ports is a skip-mode run whose active set is sparse and cut short by the vector length. Only test opcodes can load the mask, so the stimulus first builds a pattern through compare and invert operations on chosen operands. It then runs arithmetic with shorter lengths against a mask that still holds set bits above them. A select built from compare, masked move, invert and masked move, and a start pulse held high during a busy run, cover the mask sequence and the ignored start.

// File: rtl/mvx_pkg.sv
package mvx_pkg;

   typedef enum logic [2:0] {
      OP_ADD   = 3'd0,
      OP_SUB   = 3'd1,
      OP_MUL   = 3'd2,
      OP_AVG   = 3'd3,
      OP_TSTZ  = 3'd4,
      OP_TSTGE = 3'd5,
      OP_MFLIP = 3'd6,
      OP_MOV   = 3'd7
   } mvx_op_e;

   function automatic logic op_writes_mask(input mvx_op_e op);
      return (op == OP_TSTZ) || (op == OP_TSTGE) || (op == OP_MFLIP);
   endfunction

endpackage

// File: rtl/mvx_elem_alu.sv
module mvx_elem_alu
   import mvx_pkg::*;
#(
   parameter int ELEM_W = 16
) (
   input  mvx_op_e           op_i,
   input  logic [ELEM_W-1:0] a_i,
   input  logic [ELEM_W-1:0] b_i,
   output logic [ELEM_W-1:0] res_o
);

   localparam int PROD_W = 2 * ELEM_W;

   logic [ELEM_W:0]   wide_sum;
   logic [PROD_W-1:0] product;

   assign wide_sum = {1'b0, a_i} + {1'b0, b_i};
   assign product  = PROD_W'(a_i) * PROD_W'(b_i);

   always_comb begin
      res_o = '0;
      unique case (op_i)
         OP_ADD:  res_o = wide_sum[ELEM_W-1:0];
         OP_SUB:  res_o = a_i - b_i;
         OP_MUL:  res_o = product[ELEM_W-1:0];
         OP_AVG:  res_o = wide_sum[ELEM_W:1];
         OP_MOV:  res_o = a_i;
         default: res_o = '0;
      endcase
   end

endmodule

// File: rtl/mvx_len_mask.sv
module mvx_len_mask #(
   parameter int NUM_ELEM = 8,
   parameter int LEN_W    = 4
) (
   input  logic [LEN_W-1:0]    len_i,
   output logic [NUM_ELEM-1:0] keep_o
);

   for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_slot
      assign keep_o[gi] = (LEN_W'(gi) < len_i);
   end

endmodule

// File: rtl/mvx_mask_gen.sv
module mvx_mask_gen
   import mvx_pkg::*;
#(
   parameter int NUM_ELEM = 8,
   parameter int ELEM_W   = 16
) (
   input  mvx_op_e                          op_i,
   input  logic [NUM_ELEM-1:0][ELEM_W-1:0]  a_i,
   input  logic [NUM_ELEM-1:0][ELEM_W-1:0]  b_i,
   input  logic [NUM_ELEM-1:0]              cur_mask_i,
   input  logic [NUM_ELEM-1:0]              keep_i,
   output logic [NUM_ELEM-1:0]              next_mask_o
);

   for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_slot
      logic is_zero;
      logic is_ge;
      logic pick;

      assign is_zero = (a_i[gi] == '0);
      assign is_ge   = ($signed(a_i[gi]) >= $signed(b_i[gi]));

      always_comb begin
         pick = 1'b0;
         unique case (op_i)
            OP_TSTZ:  pick = is_zero;
            OP_TSTGE: pick = is_ge;
            OP_MFLIP: pick = ~cur_mask_i[gi];
            default:  pick = cur_mask_i[gi];
         endcase
      end

      assign next_mask_o[gi] = keep_i[gi] & pick;
   end

endmodule

// File: rtl/mvx_first_set.sv
module mvx_first_set #(
   parameter int NUM_ELEM = 8,
   parameter int IDX_W    = 3
) (
   input  logic [NUM_ELEM-1:0] vec_i,
   output logic [IDX_W-1:0]    idx_o,
   output logic                any_o,
   output logic                many_o
);

   always_comb begin
      idx_o = '0;
      any_o = 1'b0;
      for (int i = NUM_ELEM - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            idx_o = IDX_W'(i);
            any_o = 1'b1;
         end
      end
   end

   assign many_o = |(vec_i & (vec_i - NUM_ELEM'(1)));

endmodule

// File: rtl/masked_vec_exec.sv
module masked_vec_exec
   import mvx_pkg::*;
#(
   parameter int NUM_ELEM = 8,
   parameter int ELEM_W   = 16,
   parameter int LEN_W    = $clog2(NUM_ELEM + 1),
   parameter int IDX_W    = $clog2(NUM_ELEM)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [2:0]                   op_i,
   input  logic                         dense_i,
   input  logic [LEN_W-1:0]             vlen_i,
   input  logic [NUM_ELEM*ELEM_W-1:0]   src_a_i,
   input  logic [NUM_ELEM*ELEM_W-1:0]   src_b_i,
   output logic                         busy_o,
   output logic                         done_o,
   output logic                         res_valid_o,
   output logic                         res_we_o,
   output logic [IDX_W-1:0]             res_idx_o,
   output logic [ELEM_W-1:0]            res_data_o,
   output logic [NUM_ELEM-1:0]          mask_o
);

   if (NUM_ELEM < 2) begin : g_bad_count
      $error("masked_vec_exec: NUM_ELEM must be at least 2");
   end
   if (ELEM_W < 2) begin : g_bad_width
      $error("masked_vec_exec: ELEM_W must be at least 2");
   end
   if (LEN_W < $clog2(NUM_ELEM + 1)) begin : g_bad_len
      $error("masked_vec_exec: LEN_W too narrow for NUM_ELEM");
   end
   if ((1 << IDX_W) < NUM_ELEM) begin : g_bad_idx
      $error("masked_vec_exec: IDX_W too narrow for NUM_ELEM");
   end

   localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(NUM_ELEM);

   // captured operation
   logic                             busy_q;
   mvx_op_e                          op_q;
   logic                             dense_q;
   logic [LEN_W-1:0]                 vlen_q;
   logic [NUM_ELEM-1:0][ELEM_W-1:0]  a_q;
   logic [NUM_ELEM-1:0][ELEM_W-1:0]  b_q;
   logic [NUM_ELEM-1:0]              mask_q;
   logic [NUM_ELEM-1:0]              pend_q;
   logic [IDX_W-1:0]                 cnt_q;

   logic [LEN_W-1:0]    vlen_clamp;
   logic [NUM_ELEM-1:0] keep_start;
   logic [NUM_ELEM-1:0] keep_run;
   logic [NUM_ELEM-1:0] mask_next;
   logic [IDX_W-1:0]    scan_idx;
   logic                scan_any;
   logic                scan_many;
   logic                is_test;
   logic                last_cycle;
   logic                elem_here;
   logic [IDX_W-1:0]    cur_idx;
   logic [ELEM_W-1:0]   alu_res;
   logic                take;

   assign vlen_clamp = (vlen_i > FULL_LEN) ? FULL_LEN : vlen_i;
   assign take       = start_i & ~busy_q;
   assign is_test    = op_writes_mask(op_q);

   mvx_len_mask #(.NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W)) u_keep_start (
      .len_i  (vlen_clamp),
      .keep_o (keep_start)
   );

   mvx_len_mask #(.NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W)) u_keep_run (
      .len_i  (vlen_q),
      .keep_o (keep_run)
   );

   mvx_mask_gen #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_mask_gen (
      .op_i        (op_q),
      .a_i         (a_q),
      .b_i         (b_q),
      .cur_mask_i  (mask_q),
      .keep_i      (keep_run),
      .next_mask_o (mask_next)
   );

   mvx_first_set #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) u_scan (
      .vec_i  (pend_q),
      .idx_o  (scan_idx),
      .any_o  (scan_any),
      .many_o (scan_many)
   );

   // slot selection and termination for the two walk modes
   always_comb begin
      if (dense_q) begin
         cur_idx    = scan_idx;
         elem_here  = scan_any;
         last_cycle = ~scan_many;
      end else begin
         cur_idx    = cnt_q;
         elem_here  = (vlen_q != '0);
         last_cycle = (vlen_q == '0) || ((LEN_W'(cnt_q) + LEN_W'(1)) == vlen_q);
      end
      if (is_test) begin
         elem_here  = 1'b0;
         last_cycle = 1'b1;
      end
   end

   mvx_elem_alu #(.ELEM_W(ELEM_W)) u_alu (
      .op_i  (op_q),
      .a_i   (a_q[cur_idx]),
      .b_i   (b_q[cur_idx]),
      .res_o (alu_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         op_q    <= OP_ADD;
         dense_q <= 1'b0;
         vlen_q  <= '0;
         a_q     <= '0;
         b_q     <= '0;
         mask_q  <= '0;
         pend_q  <= '0;
         cnt_q   <= '0;
      end else if (take) begin
         busy_q  <= 1'b1;
         op_q    <= mvx_op_e'(op_i);
         dense_q <= dense_i;
         vlen_q  <= vlen_clamp;
         a_q     <= src_a_i;
         b_q     <= src_b_i;
         pend_q  <= mask_q & keep_start;
         cnt_q   <= '0;
      end else if (busy_q) begin
         if (last_cycle) begin
            busy_q <= 1'b0;
            if (is_test) begin
               mask_q <= mask_next;
            end
         end else begin
            cnt_q  <= cnt_q + IDX_W'(1);
            pend_q <= pend_q & ~(NUM_ELEM'(1) << cur_idx);
         end
      end
   end

   assign busy_o      = busy_q;
   assign done_o      = busy_q & last_cycle;
   assign res_valid_o = busy_q & elem_here;
   assign res_we_o    = busy_q & elem_here & (dense_q | mask_q[cur_idx]);
   assign res_idx_o   = cur_idx;
   assign res_data_o  = alu_res;
   assign mask_o      = mask_q;

endmodule

// File: rtl/masked_vec_exec_chk.sv
module masked_vec_exec_chk #(
   parameter int NUM_ELEM = 8,
   parameter int LEN_W    = 4,
   parameter int IDX_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy_o,
   input logic                done_o,
   input logic                res_valid_o,
   input logic                res_we_o,
   input logic [IDX_W-1:0]    res_idx_o,
   input logic [NUM_ELEM-1:0] mask_o,
   input logic                dense_q,
   input logic                is_test,
   input logic [LEN_W-1:0]    vlen_q
);

   assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o |=> busy_o);

   assert_idle_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   assert_dense_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && dense_q |-> res_we_o);

   assert_idx_in_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (LEN_W'(res_idx_o) < vlen_q));

   assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && !done_o |=> !res_valid_o || (res_idx_o > $past(res_idx_o)));

   assert_test_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && is_test |-> !res_valid_o && done_o);

   assert_mask_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && is_test) |=> $stable(mask_o));

endmodule

bind masked_vec_exec masked_vec_exec_chk #(
   .NUM_ELEM (NUM_ELEM),
   .LEN_W    (LEN_W),
   .IDX_W    (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .res_valid_o (res_valid_o),
   .res_we_o    (res_we_o),
   .res_idx_o   (res_idx_o),
   .mask_o      (mask_o),
   .dense_q     (dense_q),
   .is_test     (is_test),
   .vlen_q      (vlen_q)
);

// File: tb/masked_vec_exec_bench.sv
module masked_vec_exec_bench;

   localparam int N      = 8;
   localparam int W      = 16;
   localparam int LW     = 4;
   localparam int IW     = 3;
   localparam int PERIOD = 10;

   typedef struct {
      int          idx;
      bit          we;
      logic [W-1:0] data;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [2:0]      op_i = '0;
   logic            dense_i = 1'b0;
   logic [LW-1:0]   vlen_i = '0;
   logic [N*W-1:0]  src_a_i = '0;
   logic [N*W-1:0]  src_b_i = '0;
   logic            busy_o, done_o, res_valid_o, res_we_o;
   logic [IW-1:0]   res_idx_o;
   logic [W-1:0]    res_data_o;
   logic [N-1:0]    mask_o;

   int     errors = 0;
   int     checks = 0;
   bit     finished = 0;
   string  cur_tag = "R1";
   exp_t   sb_q[$];
   logic [N-1:0] mdl_mask = '0;

   always #(PERIOD/2) clk = ~clk;

   masked_vec_exec #(.NUM_ELEM(N), .ELEM_W(W), .LEN_W(LW), .IDX_W(IW)) u_masked_vec_exec (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .dense_i(dense_i),
      .vlen_i(vlen_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .busy_o(busy_o),
      .done_o(done_o), .res_valid_o(res_valid_o), .res_we_o(res_we_o),
      .res_idx_o(res_idx_o), .res_data_o(res_data_o), .mask_o(mask_o)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [N*W-1:0] pack(input int v [N]);
      logic [N*W-1:0] r = '0;
      for (int i = 0; i < N; i++) r[i*W +: W] = v[i][W-1:0];
      return r;
   endfunction

   function automatic logic [W-1:0] model_op(input int op, input logic [W-1:0] a,
                                               input logic [W-1:0] b);
      logic [2*W-1:0] p;
      logic [W:0] s;
      s = {1'b0, a} + {1'b0, b};
      p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      case (op)
         0: return s[W-1:0];
         1: return a - b;
         2: return p[W-1:0];
         3: return s[W:1];
         default: return a;
      endcase
   endfunction

   // monitor: pops the scoreboard whenever a result element appears
   always @(negedge clk) begin
      if (rst_n && res_valid_o) begin
         if (sb_q.size() == 0) begin
            check(0, cur_tag, "unexpected result idx", res_idx_o, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check((int'(res_idx_o) == e.idx) && (res_we_o == e.we) && (res_data_o == e.data),
                  cur_tag, "result {idx,we,data}",
                  {32'(res_idx_o), 15'd0, res_we_o, res_data_o},
                  {32'(e.idx), 15'd0, e.we, e.data});
         end
      end
   end

   // driver: predicts the run, pushes expected items, drives one operation
   task automatic run_op(input int op, input bit dense, input int vlen,
                         input logic [N*W-1:0] a, input logic [N*W-1:0] b,
                         input string tag, input bit poke);
      int veff, count, cyc;
      logic [N-1:0] next_mask;
      bit is_test;
      veff = (vlen > N) ? N : vlen;
      is_test = (op >= 4 && op <= 6);
      count = 0;
      next_mask = mdl_mask;
      cur_tag = tag;
      if (is_test) begin
         for (int i = 0; i < N; i++) begin
            logic [W-1:0] ea, eb;
            bit bitv;
            ea = a[i*W +: W];
            eb = b[i*W +: W];
            if (op == 4) bitv = (ea == 0);
            else if (op == 5) bitv = ($signed(ea) >= $signed(eb));
            else bitv = ~mdl_mask[i];
            next_mask[i] = (i < veff) ? bitv : 1'b0;
         end
      end else begin
         for (int i = 0; i < veff; i++) begin
            exp_t e;
            if (dense && !mdl_mask[i]) continue;
            e.idx = i;
            e.we = dense ? 1'b1 : mdl_mask[i];
            e.data = model_op(op, a[i*W +: W], b[i*W +: W]);
            sb_q.push_back(e);
            count++;
         end
      end
      @(negedge clk);
      start_i = 1'b1; op_i = op[2:0]; dense_i = dense; vlen_i = vlen[LW-1:0];
      src_a_i = a; src_b_i = b;
      @(negedge clk);
      start_i = poke;
      op_i = 3'd6; src_a_i = ~a;
      cyc = 1;
      while (!done_o && cyc < 40) begin
         @(negedge clk);
         cyc++;
         start_i = 1'b0;
      end
      start_i = 1'b0;
      check(done_o === 1'b1, tag, "done seen", done_o, 1);
      check(cyc == ((is_test || count == 0) ? 1 : count), tag, "run length in cycles",
            cyc, (is_test || count == 0) ? 1 : count);
      @(negedge clk);
      mdl_mask = next_mask;
      check(sb_q.size() == 0, tag, "results left unseen", sb_q.size(), 0);
      sb_q.delete();
      check(busy_o == 1'b0, poke ? "R10" : tag, "idle after done", busy_o, 0);
      check(mask_o == mdl_mask, is_test ? tag : "R11", "mask register", mask_o, mdl_mask);
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      logic [N*W-1:0] va, vb, zero_v, ones_v;
      zero_v = '0;
      ones_v = pack('{1, 1, 1, 1, 1, 1, 1, 1});
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy_o == 0 && res_valid_o == 0 && done_o == 0, "R1", "idle outputs",
            {busy_o, res_valid_o, done_o}, 0);
      check(mask_o == 0, "R1", "mask after reset", mask_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 nothing to emit: zero mask in skip mode, and length 0 in sweep mode
      va = pack('{5, 6, 7, 8, 9, 10, 11, 12});
      run_op(0, 1, 8, va, va, "R8", 0);
      run_op(0, 0, 0, va, va, "R8", 0);

      // R3 zero test, element ops under that mask
      va = pack('{3, 0, 9, 0, 0, 4, 100, 7});
      vb = pack('{10, 20, 30, 40, 50, 60, 70, 80});
      run_op(4, 0, 8, va, vb, "R3", 0);
      run_op(0, 0, 8, va, vb, "R6", 0);
      run_op(0, 1, 8, va, vb, "R7", 0);

      // R2 remaining arithmetic in sweep mode, with wrap-around values
      run_op(4, 0, 8, zero_v, vb, "R3", 0);
      va = pack('{16'hFFFF, 16'h8000, 300, 7, 16'hFFFE, 1, 255, 16'h1234});
      vb = pack('{2, 16'h8000, 300, 9, 16'hFFFF, 3, 257, 16'h4321});
      run_op(1, 0, 8, va, vb, "R2", 0);
      run_op(2, 0, 8, va, vb, "R2", 0);
      run_op(3, 0, 8, va, vb, "R2", 0);
      run_op(0, 0, 8, va, vb, "R2", 0);

      // R9 short length with upper mask bits set, and clamped length
      run_op(7, 1, 3, va, vb, "R9", 0);
      run_op(7, 0, 3, va, vb, "R9", 0);
      run_op(0, 0, 12, va, vb, "R9", 0);
      run_op(4, 0, 5, zero_v, vb, "R3", 0);
      run_op(0, 1, 8, va, vb, "R9", 0);

      // R4 signed compare, R5 invert: select as two masked moves
      va = pack('{1, 2, 3, 4, -5, 0, 6, -7});
      vb = pack('{2, 2, 2, 10, -4, -3, 5, -8});
      run_op(5, 0, 8, va, vb, "R4", 0);
      run_op(7, 1, 8, va, vb, "R7", 0);
      run_op(6, 0, 8, va, vb, "R5", 0);
      run_op(7, 1, 8, vb, va, "R7", 0);
      run_op(6, 0, 6, va, vb, "R5", 0);

      // R10 start held during a busy run is ignored
      run_op(4, 0, 8, zero_v, vb, "R3", 0);
      run_op(0, 0, 8, ones_v, va, "R10", 1);
      run_op(0, 1, 8, ones_v, vb, "R10", 1);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule